// File: doc/BRIEF.md
# Hot-Plug Slot Command Engine

This block takes the command byte and target number written to a hot-plug controller and carries the command out against a bank of slot records. Each slot record holds a 2-bit slot state, a 2-bit power-indicator code, a 2-bit attention-indicator code, a latch-open bit and a 2-bit presence code. The block also keeps two sticky event bits per slot, one for the latch and one for presence.

A single-slot command packs the new state and both indicator codes into one 6-bit value. A zero field leaves that item as it is. Two broadcast commands check every slot first and then walk the slots one per cycle. A slot with a closed latch is brought up. A slot with an open latch only gets its power indicator switched off. Bus-speed commands accept only the 33 MHz setting.

When a slot goes into the fully off condition, the block does not remove the device itself. It raises a one-cycle per-slot strobe, opens the latch, marks the slot empty and latches both events. The surrounding logic is left to act on the strobe. A separate per-slot insert strobe from outside marks a card as seated.

Top module: `hp_cmd_engine`

## Requirements
- R1: Codes 0x00 to 0x3F act on one slot. Bits [1:0] give the new state (1 power only, 2 enabled, 3 disabled), bits [3:2] give the power indicator and bits [5:4] the attention indicator (1 on, 2 blinking, 3 off). A field of 0 keeps the current value.
- R2: The slot index is the target minus 1. A target of 0, or a target above NSLOTS, sets the invalid-command flag (status bit 2) and leaves every slot unchanged.
- R3: A single-slot command that asks for state 1 on a slot whose state is 2 sets the invalid-command flag and changes nothing.
- R4: Codes 0x40 to 0x47 are bus-speed commands. A low 3-bit value of 0 is accepted. Any other value sets the invalid-mode flag (status bit 3), and no slot changes.
- R5: Code 0x48 (power only, all slots) and code 0x49 (enable all slots) set the invalid-command flag and change nothing if any slot's state is 2.
- R6: When the check of R5 passes, each slot in index order is handled as follows. With its latch closed, it takes state 1 (for 0x48) or state 2 (for 0x49) and power indicator 1. With its latch open, only its power indicator is set to 3. The attention indicator is not touched.
- R7: Codes 0x4A to 0xFF set the invalid-command flag and change nothing.
- R8: On the clock edge that takes a write, the busy flag (status bit 0) is set and status bits 3:1 are cleared. Busy falls one cycle later for a single-slot, speed, invalid or failed command, and NSLOTS+1 cycles later for a broadcast command that passes its check. Status bit 1 always reads 0.
- R9: A slot that moves from not off to off (state 3 with power indicator 3) gets its latch-open bit set, presence 3, both event bits set, and a one-cycle pulse on its slot_off bit. This happens in the same cycle as the field update.
- R10: Every command, valid or not, gives a one-cycle cmd_detected pulse in the cycle in which busy falls.
- R11: A write that arrives while a command is in progress is ignored.
- R12: After reset, every slot reads state 3, both indicators 3, latch open and presence 3, with events, status and cmd_detected at 0. A slot_insert pulse clears the latch bit and sets presence 0. A slot_evt_clr pulse clears both event bits of that slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_wr | input | 1 | Command byte write strobe |
| cmd_code | input | 8 | Command code |
| cmd_target | input | 5 | Target slot number (1-based) |
| slot_insert | input | NSLOTS | Per-slot card-seated pulse |
| slot_evt_clr | input | NSLOTS | Per-slot event clear pulse |
| slot_state | output | 2*NSLOTS | Slot states, slot i at [2i+1:2i] |
| slot_pwr_ind | output | 2*NSLOTS | Power indicator codes |
| slot_attn_ind | output | 2*NSLOTS | Attention indicator codes |
| slot_presence | output | 2*NSLOTS | Presence codes (3 = empty) |
| slot_latch_open | output | NSLOTS | Latch-open bits |
| slot_evt_mrl | output | NSLOTS | Sticky latch event bits |
| slot_evt_prs | output | NSLOTS | Sticky presence event bits |
| slot_off | output | NSLOTS | One-cycle slot-turned-off strobe |
| cmd_status | output | 4 | {invalid mode, invalid command, 0, busy} |
| cmd_detected | output | 1 | One-cycle command-complete pulse |

## Verification
A slot record that is wrong shows up on the slot field outputs in the same cycle as cmd_detected. The outputs are compared against an arithmetic model after every command over a sweep of all 64 packed codes and all 32 targets. A mistake in the broadcast walk, such as a wrong index, a skipped slot or the latch read on the wrong slot, changes the number of busy cycles or leaves one slot's fields wrong at completion. A missed turn-off shows up right away as a missing slot_off strobe, or as latch, presence and event bits that still hold their old values.

// File: rtl/hp_cmd_engine.sv
module hp_cmd_engine #(
  parameter int NSLOTS = 31
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cmd_wr,
  input  logic [7:0]            cmd_code,
  input  logic [4:0]            cmd_target,
  input  logic [NSLOTS-1:0]     slot_insert,
  input  logic [NSLOTS-1:0]     slot_evt_clr,
  output logic [2*NSLOTS-1:0]   slot_state,
  output logic [2*NSLOTS-1:0]   slot_pwr_ind,
  output logic [2*NSLOTS-1:0]   slot_attn_ind,
  output logic [2*NSLOTS-1:0]   slot_presence,
  output logic [NSLOTS-1:0]     slot_latch_open,
  output logic [NSLOTS-1:0]     slot_evt_mrl,
  output logic [NSLOTS-1:0]     slot_evt_prs,
  output logic [NSLOTS-1:0]     slot_off,
  output logic [3:0]            cmd_status,
  output logic                  cmd_detected
);
  localparam logic [4:0] LAST  = 5'(NSLOTS - 1);
  localparam logic [4:0] COUNT = 5'(NSLOTS);

  typedef enum logic [1:0] {IDLE, EXEC, SWEEP} phase_t;

  phase_t      phase;
  logic [7:0]  code_q;
  logic [4:0]  tgt_q, idx_q;
  logic        busy_q, inv_cmd_q, inv_mode_q, det_q;

  logic [1:0]  st_q [NSLOTS];
  logic [1:0]  pw_q [NSLOTS];
  logic [1:0]  at_q [NSLOTS];
  logic [1:0]  pr_q [NSLOTS];
  logic [NSLOTS-1:0] lo_q, em_q, ep_q, off_q;

  logic [4:0]  sel;
  logic [1:0]  sel_st, sel_pw, sel_at;
  logic        sel_lo, any_en;
  logic [1:0]  req_s, req_p, req_a, new_s, new_p, new_a;
  logic        tgt_ok, is_slot, is_speed, is_bc, single_ok, apply, turn_off;

  always_comb begin
    any_en = 1'b0;
    sel_st = 2'd0;
    sel_pw = 2'd0;
    sel_at = 2'd0;
    sel_lo = 1'b0;
    for (int i = 0; i < NSLOTS; i++) begin
      if (st_q[i] == 2'd2) any_en = 1'b1;
      if (5'(i) == sel) begin
        sel_st = st_q[i];
        sel_pw = pw_q[i];
        sel_at = at_q[i];
        sel_lo = lo_q[i];
      end
    end
  end

  assign tgt_ok   = (tgt_q != 5'd0) && (tgt_q <= COUNT);
  assign sel      = (phase == SWEEP) ? idx_q : (tgt_q - 5'd1);
  assign is_slot  = code_q[7:6] == 2'b00;
  assign is_speed = code_q[7:3] == 5'b01000;
  assign is_bc    = (code_q == 8'h48) || (code_q == 8'h49);

  always_comb begin
    if (phase == SWEEP) begin
      req_s = sel_lo ? 2'd0 : (code_q[0] ? 2'd2 : 2'd1);
      req_p = sel_lo ? 2'd3 : 2'd1;
      req_a = 2'd0;
    end else begin
      req_s = code_q[1:0];
      req_p = code_q[3:2];
      req_a = code_q[5:4];
    end
  end

  assign single_ok = (phase == EXEC) && is_slot && tgt_ok &&
                     !(sel_st == 2'd2 && req_s == 2'd1);
  assign apply    = single_ok || (phase == SWEEP);
  assign new_s    = (req_s == 2'd0) ? sel_st : req_s;
  assign new_p    = (req_p == 2'd0) ? sel_pw : req_p;
  assign new_a    = (req_a == 2'd0) ? sel_at : req_a;
  assign turn_off = apply && !(sel_st == 2'd3 && sel_pw == 2'd3) &&
                    (new_s == 2'd3 && new_p == 2'd3);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase      <= IDLE;
      code_q     <= 8'd0;
      tgt_q      <= 5'd0;
      idx_q      <= 5'd0;
      busy_q     <= 1'b0;
      inv_cmd_q  <= 1'b0;
      inv_mode_q <= 1'b0;
      det_q      <= 1'b0;
    end else begin
      det_q <= 1'b0;
      case (phase)
        IDLE: if (cmd_wr) begin
          code_q     <= cmd_code;
          tgt_q      <= cmd_target;
          busy_q     <= 1'b1;
          inv_cmd_q  <= 1'b0;
          inv_mode_q <= 1'b0;
          phase      <= EXEC;
        end
        EXEC: begin
          phase  <= IDLE;
          busy_q <= 1'b0;
          det_q  <= 1'b1;
          if (is_slot) begin
            if (!single_ok) inv_cmd_q <= 1'b1;
          end else if (is_speed) begin
            if (code_q[2:0] != 3'd0) inv_mode_q <= 1'b1;
          end else if (is_bc) begin
            if (any_en) inv_cmd_q <= 1'b1;
            else begin
              phase  <= SWEEP;
              busy_q <= 1'b1;
              det_q  <= 1'b0;
              idx_q  <= 5'd0;
            end
          end else begin
            inv_cmd_q <= 1'b1;
          end
        end
        default: begin
          if (idx_q == LAST) begin
            phase  <= IDLE;
            busy_q <= 1'b0;
            det_q  <= 1'b1;
          end else begin
            idx_q <= idx_q + 5'd1;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NSLOTS; i++) begin
        st_q[i] <= 2'd3;
        pw_q[i] <= 2'd3;
        at_q[i] <= 2'd3;
        pr_q[i] <= 2'd3;
      end
      lo_q  <= '1;
      em_q  <= '0;
      ep_q  <= '0;
      off_q <= '0;
    end else begin
      for (int i = 0; i < NSLOTS; i++) begin
        off_q[i] <= 1'b0;
        if (slot_evt_clr[i]) begin
          em_q[i] <= 1'b0;
          ep_q[i] <= 1'b0;
        end
        if (slot_insert[i]) begin
          lo_q[i] <= 1'b0;
          pr_q[i] <= 2'd0;
        end
        if (apply && sel == 5'(i)) begin
          st_q[i] <= new_s;
          pw_q[i] <= new_p;
          at_q[i] <= new_a;
          if (turn_off) begin
            lo_q[i]  <= 1'b1;
            pr_q[i]  <= 2'd3;
            em_q[i]  <= 1'b1;
            ep_q[i]  <= 1'b1;
            off_q[i] <= 1'b1;
          end
        end
      end
    end
  end

  for (genvar g = 0; g < NSLOTS; g++) begin : g_pack
    assign slot_state[2*g +: 2]    = st_q[g];
    assign slot_pwr_ind[2*g +: 2]  = pw_q[g];
    assign slot_attn_ind[2*g +: 2] = at_q[g];
    assign slot_presence[2*g +: 2] = pr_q[g];
  end

  assign slot_latch_open = lo_q;
  assign slot_evt_mrl    = em_q;
  assign slot_evt_prs    = ep_q;
  assign slot_off        = off_q;
  assign cmd_status      = {inv_mode_q, inv_cmd_q, 1'b0, busy_q};
  assign cmd_detected    = det_q;
endmodule

// File: rtl/hp_cmd_engine_chk.sv
module hp_cmd_engine_chk #(
  parameter int NSLOTS = 31
) (
  input logic                clk,
  input logic                rst_n,
  input logic [3:0]          cmd_status,
  input logic                cmd_detected,
  input logic [2*NSLOTS-1:0] slot_state,
  input logic [NSLOTS-1:0]   slot_off,
  input logic [NSLOTS-1:0]   slot_latch_open
);
  // R10
  det_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_detected |-> $past(cmd_status[0]));
  // R10
  det_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_detected |=> !cmd_detected);
  // R8
  busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cmd_status[0]) |-> cmd_detected);
  // R8
  flags_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_status[0]) |-> cmd_status[3:1] == 3'd0);
  // R9
  off_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|slot_off) |-> ((slot_off & ~slot_latch_open) == '0));

  for (genvar g = 0; g < NSLOTS; g++) begin : g_slot
    // R3
    en_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(slot_state[2*g +: 2]) == 2'd2) |-> (slot_state[2*g +: 2] != 2'd1));
  end
endmodule

bind hp_cmd_engine hp_cmd_engine_chk #(.NSLOTS(NSLOTS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_status(cmd_status), .cmd_detected(cmd_detected),
  .slot_state(slot_state), .slot_off(slot_off), .slot_latch_open(slot_latch_open));

// File: tb/sim_hp_cmd_engine.sv
module sim_hp_cmd_engine;
  localparam int N = 4;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, cmd_wr = 1'b0;
  logic [7:0] cmd_code = 8'd0;
  logic [4:0] cmd_target = 5'd0;
  logic [N-1:0] slot_insert = '0, slot_evt_clr = '0;
  logic [2*N-1:0] slot_state, slot_pwr_ind, slot_attn_ind, slot_presence;
  logic [N-1:0] slot_latch_open, slot_evt_mrl, slot_evt_prs, slot_off;
  logic [3:0] cmd_status;
  logic cmd_detected;

  int total = 0, bad = 0;
  bit done = 0;

  logic [1:0] m_st [N], m_pw [N], m_at [N], m_pr [N];
  logic [N-1:0] m_lo, m_em, m_ep, exp_off;

  hp_cmd_engine #(.NSLOTS(N)) u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input longint act, input longint exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [2*N-1:0] pk(input int f);
    logic [2*N-1:0] v;
    for (int i = 0; i < N; i++)
      v[2*i +: 2] = (f == 0) ? m_st[i] : (f == 1) ? m_pw[i] : (f == 2) ? m_at[i] : m_pr[i];
    return v;
  endfunction

  task automatic check_slots(input string tag);
    chk({tag, " state"}, longint'(slot_state), longint'(pk(0)));
    chk({tag, " pwr"}, longint'(slot_pwr_ind), longint'(pk(1)));
    chk({tag, " attn"}, longint'(slot_attn_ind), longint'(pk(2)));
    chk({tag, " R9 presence"}, longint'(slot_presence), longint'(pk(3)));
    chk({tag, " R9 latch"}, longint'(slot_latch_open), longint'(m_lo));
    chk({tag, " R9 events"}, longint'({slot_evt_mrl, slot_evt_prs}), longint'({m_em, m_ep}));
  endtask

  task automatic m_apply(input int i, input logic [1:0] s, input logic [1:0] p, input logic [1:0] a);
    logic was_off;
    was_off = (m_st[i] == 2'd3) && (m_pw[i] == 2'd3);
    if (s != 0) m_st[i] = s;
    if (p != 0) m_pw[i] = p;
    if (a != 0) m_at[i] = a;
    if (!was_off && m_st[i] == 2'd3 && m_pw[i] == 2'd3) begin
      m_lo[i] = 1'b1; m_pr[i] = 2'd3; m_em[i] = 1'b1; m_ep[i] = 1'b1; exp_off[i] = 1'b1;
    end
  endtask

  task automatic run_cmd(input logic [7:0] code, input logic [4:0] tgt, input bit intrude);
    logic inv, mode, any;
    int exp_steps, steps;
    logic [N-1:0] seen;
    string cat;
    inv = 0; mode = 0; exp_steps = 1; exp_off = '0; seen = '0;
    any = 0;
    for (int i = 0; i < N; i++) if (m_st[i] == 2'd2) any = 1;
    if (code[7:6] == 2'b00) begin
      if (tgt == 0 || tgt > N) begin inv = 1; cat = "R2"; end
      else if (code[1:0] == 2'd1 && m_st[tgt-1] == 2'd2) begin inv = 1; cat = "R3"; end
      else begin cat = "R1"; m_apply(int'(tgt) - 1, code[1:0], code[3:2], code[5:4]); end
    end else if (code[7:3] == 5'b01000) begin
      cat = "R4"; mode = (code[2:0] != 3'd0);
    end else if (code == 8'h48 || code == 8'h49) begin
      if (any) begin inv = 1; cat = "R5"; end
      else begin
        cat = "R6"; exp_steps = N + 1;
        for (int i = 0; i < N; i++)
          if (!m_lo[i]) m_apply(i, (code == 8'h49) ? 2'd2 : 2'd1, 2'd1, 2'd0);
          else m_apply(i, 2'd0, 2'd3, 2'd0);
      end
    end else begin
      inv = 1; cat = "R7";
    end
    @(negedge clk); cmd_code = code; cmd_target = tgt; cmd_wr = 1'b1;
    @(negedge clk); cmd_wr = 1'b0;
    chk("R8 start status", longint'(cmd_status), 64'h1);
    steps = 0;
    do begin
      if (intrude && steps == 0) begin cmd_code = 8'h3F; cmd_target = 5'd1; cmd_wr = 1'b1; end
      @(negedge clk);
      cmd_wr = 1'b0;
      seen |= slot_off;
      steps++;
    end while (!cmd_detected && steps < 100);
    chk("R8 latency", longint'(steps), longint'(exp_steps));
    chk({cat, " R10 status"}, longint'({cmd_detected, cmd_status}),
        longint'({1'b1, mode, inv, 2'b00}));
    chk("R9 off strobe", longint'(seen), longint'(exp_off));
    check_slots(intrude ? {cat, " R11"} : cat);
    @(negedge clk);
    chk("R10 single pulse", longint'(cmd_detected), 0);
  endtask

  task automatic insert(input logic [N-1:0] m);
    @(negedge clk); slot_insert = m;
    @(negedge clk); slot_insert = '0;
    for (int i = 0; i < N; i++) if (m[i]) begin m_lo[i] = 1'b0; m_pr[i] = 2'd0; end
    check_slots("R12 insert");
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin m_st[i] = 3; m_pw[i] = 3; m_at[i] = 3; m_pr[i] = 3; end
    m_lo = '1; m_em = '0; m_ep = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    check_slots("R12 reset");
    chk("R12 reset status", longint'({cmd_detected, cmd_status}), 0);
    insert('1);
    // R1 R2 R3 R9: all packed codes on all targets
    for (int c = 0; c < 64; c++) begin
      for (int t = 0; t < 32; t++) run_cmd(8'(c), 5'(t), 1'b0);
      insert('1);
    end
    // R4 R5 R6 R7: every other code once
    for (int c = 64; c < 256; c++) run_cmd(8'(c), 5'd1, 1'b0);
    // directed broadcast sequence
    for (int t = 1; t <= N; t++) run_cmd(8'h3F, 5'(t), 1'b0);
    insert(4'b0011);
    run_cmd(8'h48, 5'd0, 1'b1);   // R6 power-only all with ignored write, R11
    run_cmd(8'h49, 5'd0, 1'b0);   // R6 enable all
    run_cmd(8'h48, 5'd0, 1'b0);   // R5 refused
    run_cmd(8'h01, 5'd1, 1'b0);   // R3 refused
    run_cmd(8'h40, 5'd0, 1'b0);   // R4 accepted
    run_cmd(8'h45, 5'd0, 1'b0);   // R4 invalid mode
    // R12 event clear
    @(negedge clk); slot_evt_clr = '1;
    @(negedge clk); slot_evt_clr = '0;
    m_em = '0; m_ep = '0;
    check_slots("R12 evt clear");
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule